// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block runs one access on an external memory bus for each accepted request. It counts every phase in bus clock cycles. It drives an address strobe, an active-low chip select, separate active-low read and write strobes, a data-drive enable for the write data and a one-cycle completion pulse. The sequencer does no address decoding and no data-width steering. It only shapes the timing of the control pins.

A 16-bit timing word is sampled when a request is accepted. Its bits 14:12 give the first-access wait count. Five single-bit options each insert one cycle at a fixed point of the cycle:
- bit 2 delays the chip select behind the address strobe,
- bit 1 adds a setup cycle between chip select and strobe,
- bit 0 adds a hold cycle at the end,
- bit 4 adds a recovery cycle after a write,
- bit 6 adds a turnaround cycle between a read and a write that directly follows it.

When the ready enable is set, an external ready line can stretch the strobe phase beyond the programmed wait count.

A request is a level sampled only while the sequencer is idle. The requester may drop it once the address strobe appears, and it learns of completion from the done pulse.

Top module: `ebus_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, addr_strobe=0, cs_n=1, rd_n=1, wr_n=1, drive_en=0 and done=0.
- R2: A request sampled high in the idle state makes addr_strobe high for exactly the next cycle. When timing bit 2 is 0, cs_n goes low in that same cycle.
- R3: When timing bit 2 is 1, cs_n stays high during the address strobe cycle and goes low in the cycle after it.
- R4: The strobe (rd_n for a read, wr_n for a write) goes low in the cycle after cs_n first goes low. Timing bit 1 set to 1 delays it by one more cycle. The other strobe stays high.
- R5: The strobe stays low for exactly N+1 cycles, where N is timing bits 14:12 (0 to 7), as long as ready stretching does not apply.
- R6: With rdy_en=1, each clock edge that ends the last programmed strobe cycle while rdy is 0 keeps the strobe low one more cycle. With rdy_en=0, rdy has no effect.
- R7: cs_n stays low for one cycle after the strobe returns high when timing bit 0 is 0, and for two cycles when it is 1.
- R8: done is high for exactly one cycle, the first cycle in which cs_n is high again.
- R9: For a write, drive_en is high from the first strobe cycle through the last hold cycle. For a read, drive_en stays low.
- R10: With the request held high from the done cycle onward, the next addr_strobe comes two cycles after the done cycle. After a write with timing bit 4 set to 1, it comes three cycles after.
- R11: After a read with timing bit 6 set to 1, the next accepted request, if it is a write, has its addr_strobe one cycle later than otherwise. A read that follows gets no extra cycle, and a write that follows a read with bit 6 clear gets none either.
- R12: A request raised while an access is in progress has no effect on the current access.
- R13: wait_cfg and req_write are sampled in the accepting cycle. Changes to them afterwards do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled in idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| wait_cfg | input | 16 | Timing word sampled at acceptance |
| rdy_en | input | 1 | Enables stretching by rdy |
| rdy | input | 1 | External ready, low stretches the strobe |
| addr_strobe | output | 1 | Address strobe, high for one cycle |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| drive_en | output | 1 | Write data drive enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the edges between phases.
- A design whose wait counter is off by one would give a strobe one cycle short or long.
- A design that samples rdy before the count runs out, or ignores rdy_en, would stretch the wrong cycles.
- Back-to-back requests held high through the done cycle expose three faults: an access started during recovery, a turnaround applied to a read, or a turnaround forgotten after a flagged read followed by an idle gap.
- Changing the timing word and direction right after acceptance, and pulsing req in mid-access, catches a design that reads its configuration live or restarts on a busy request.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TURN,
    ST_ADDR,
    ST_CSDLY,
    ST_SETUP,
    ST_STRB,
    ST_HOLD,
    ST_HOLD2,
    ST_FIN,
    ST_RECOV
  } seq_state_e;

  typedef struct packed {
    logic turn;
    logic recov;
    logic cs_dly;
    logic setup;
    logic hold;
  } seq_opts_t;

endpackage

// File: rtl/ebus_cfg_capture.sv
module ebus_cfg_capture
  import ebus_seq_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int WAIT_LSB  = 12,
  parameter int WAIT_W    = 3,
  parameter int BIT_TURN  = 6,
  parameter int BIT_RECOV = 4,
  parameter int BIT_CSDLY = 2,
  parameter int BIT_SETUP = 1,
  parameter int BIT_HOLD  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic              wr_in,
  output seq_opts_t         opts_q,
  output seq_opts_t         opts_d,
  output logic [WAIT_W-1:0] wait_q,
  output logic              wr_q,
  output logic              wr_d
);

  seq_opts_t in_opts;

  always_comb begin
    in_opts.turn   = cfg_in[BIT_TURN];
    in_opts.recov  = cfg_in[BIT_RECOV];
    in_opts.cs_dly = cfg_in[BIT_CSDLY];
    in_opts.setup  = cfg_in[BIT_SETUP];
    in_opts.hold   = cfg_in[BIT_HOLD];
  end

  assign opts_d = capture ? in_opts : opts_q;
  assign wr_d   = capture ? wr_in : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opts_q <= '0;
      wait_q <= '0;
      wr_q   <= 1'b0;
    end else if (capture) begin
      opts_q <= in_opts;
      wait_q <= cfg_in[WAIT_LSB +: WAIT_W];
      wr_q   <= wr_in;
    end
  end

endmodule

// File: rtl/ebus_wait_ctr.sv
module ebus_wait_ctr #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              zero
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5: the strobe counter is only stepped while it has cycles left
  p_dec_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));

endmodule

// File: rtl/ebus_pin_drive.sv
module ebus_pin_drive
  import ebus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e nxt_state,
  input  logic       cs_dly_d,
  input  logic       wr_d,
  output logic       addr_strobe,
  output logic       cs_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic       drive_en,
  output logic       done
);

  logic cs_on, strb_on, drv_on;

  always_comb begin
    strb_on = (nxt_state == ST_STRB);
    drv_on  = wr_d && (nxt_state inside {ST_STRB, ST_HOLD, ST_HOLD2});
    cs_on   = (nxt_state inside {ST_CSDLY, ST_SETUP, ST_STRB, ST_HOLD, ST_HOLD2})
              || ((nxt_state == ST_ADDR) && !cs_dly_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_strobe <= 1'b0;
      cs_n        <= 1'b1;
      rd_n        <= 1'b1;
      wr_n        <= 1'b1;
      drive_en    <= 1'b0;
      done        <= 1'b0;
    end else begin
      addr_strobe <= (nxt_state == ST_ADDR);
      cs_n        <= !cs_on;
      rd_n        <= !(strb_on && !wr_d);
      wr_n        <= !(strb_on && wr_d);
      drive_en    <= drv_on;
      done        <= (nxt_state == ST_FIN);
    end
  end

  p_as_single_r2: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> !addr_strobe);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !cs_n);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_cs_rise_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !$past(cs_n)));

  p_read_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !drive_en);

endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
  import ebus_seq_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int WAIT_LSB  = 12,
  parameter int WAIT_W    = 3,
  parameter int BIT_TURN  = 6,
  parameter int BIT_RECOV = 4,
  parameter int BIT_CSDLY = 2,
  parameter int BIT_SETUP = 1,
  parameter int BIT_HOLD  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_write,
  input  logic [CFG_W-1:0] wait_cfg,
  input  logic             rdy_en,
  input  logic             rdy,
  output logic             addr_strobe,
  output logic             cs_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             drive_en,
  output logic             done
);

  seq_state_e        state_q, state_d;
  seq_opts_t         opts_q, opts_d;
  logic [WAIT_W-1:0] wait_q;
  logic              wr_q, wr_d;
  logic              accept, cnt_zero, cnt_load, cnt_dec, turn_q;

  assign accept = (state_q == ST_IDLE) && req;

  ebus_cfg_capture #(
    .CFG_W(CFG_W), .WAIT_LSB(WAIT_LSB), .WAIT_W(WAIT_W),
    .BIT_TURN(BIT_TURN), .BIT_RECOV(BIT_RECOV), .BIT_CSDLY(BIT_CSDLY),
    .BIT_SETUP(BIT_SETUP), .BIT_HOLD(BIT_HOLD)
  ) u_cfg (
    .clk(clk), .rst(rst), .capture(accept), .cfg_in(wait_cfg), .wr_in(req_write),
    .opts_q(opts_q), .opts_d(opts_d), .wait_q(wait_q), .wr_q(wr_q), .wr_d(wr_d)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req) state_d = (req_write && turn_q) ? ST_TURN : ST_ADDR;
      ST_TURN:  state_d = ST_ADDR;
      ST_ADDR:  state_d = opts_q.cs_dly ? ST_CSDLY : (opts_q.setup ? ST_SETUP : ST_STRB);
      ST_CSDLY: state_d = opts_q.setup ? ST_SETUP : ST_STRB;
      ST_SETUP: state_d = ST_STRB;
      ST_STRB:  if (cnt_zero && !(rdy_en && !rdy)) state_d = ST_HOLD;
      ST_HOLD:  state_d = opts_q.hold ? ST_HOLD2 : ST_FIN;
      ST_HOLD2: state_d = ST_FIN;
      ST_FIN:   state_d = (wr_q && opts_q.recov) ? ST_RECOV : ST_IDLE;
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      turn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)
        turn_q <= 1'b0;
      else if (state_q == ST_FIN && !wr_q && opts_q.turn)
        turn_q <= 1'b1;
    end
  end

  assign cnt_load = (state_q != ST_STRB) && (state_d == ST_STRB);
  assign cnt_dec  = (state_q == ST_STRB) && !cnt_zero;

  ebus_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(wait_q),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  ebus_pin_drive u_pins (
    .clk(clk), .rst(rst), .nxt_state(state_d), .cs_dly_d(opts_d.cs_dly), .wr_d(wr_d),
    .addr_strobe(addr_strobe), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .drive_en(drive_en), .done(done)
  );

  // R11: a turnaround cycle always leads straight into the address phase
  p_turn_to_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TURN) |=> (state_q == ST_ADDR));

  // R12: a busy sequencer never re-enters the address phase from mid-access
  p_no_restart_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_STRB, ST_HOLD, ST_HOLD2}) |=> (state_q != ST_ADDR));

  // R6: without ready stretching the strobe ends once the count is spent
  p_no_stretch_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STRB && cnt_zero && !rdy_en) |=> (state_q == ST_HOLD));

endmodule

// File: tb/ebus_cycle_seq_bench.sv
module ebus_cycle_seq_bench;

  typedef struct {
    logic [5:0] pins;   // {addr_strobe, cs_n, rd_n, wr_n, drive_en, done}
    logic       rdy;
    string      tag;
  } exp_t;

  localparam logic [5:0] IDLE_PINS = 6'b011100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] wait_cfg = '0;
  logic        rdy_en = 1'b0;
  logic        rdy = 1'b1;
  logic        addr_strobe, cs_n, rd_n, wr_n, drive_en, done;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    turn_m = 1'b0;
  string idle_tag = "R1";
  exp_t  q[$];

  always #10 clk = ~clk;

  ebus_cycle_seq u_ebus_cycle_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .wait_cfg(wait_cfg),
    .rdy_en(rdy_en), .rdy(rdy), .addr_strobe(addr_strobe), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .drive_en(drive_en), .done(done)
  );

  function automatic exp_t mk(input logic [5:0] p, input logic r, input string t);
    exp_t e;
    e.pins = p;
    e.rdy  = r;
    e.tag  = t;
    return e;
  endfunction

  task automatic tick();
    exp_t e;
    logic [5:0] act;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = mk(IDLE_PINS, 1'b1, idle_tag);
    act = {addr_strobe, cs_n, rd_n, wr_n, drive_en, done};
    checks++;
    if (act !== e.pins) begin
      errors++;
      $display("FAIL %s cycle %0d: pins actual %b expected %b (as,cs_n,rd_n,wr_n,de,done)",
               e.tag, cyc, act, e.pins);
    end
    rdy = e.rdy;
  endtask

  task automatic flush();
    while (q.size() > 0) tick();
    tick();
  endtask

  // One access; b2b = request raised in the done cycle of the previous one
  task automatic access(input bit wr, input logic [15:0] cfg, input bit ren,
                        input int extra, input bit b2b, input bit poke);
    int w     = int'(cfg[14:12]);
    int nstrb = w + 1 + (ren ? extra : 0);
    int n_pre;
    int rem;
    logic [5:0] sp;
    if (b2b) q.push_back(mk(IDLE_PINS, 1'b1, "R10"));
    n_pre = q.size();
    if (wr && turn_m) q.push_back(mk(IDLE_PINS, 1'b1, "R11"));
    q.push_back(mk({1'b1, cfg[2], 4'b1100}, 1'b1, cfg[2] ? "R3" : "R2"));
    if (cfg[2]) q.push_back(mk(6'b000100 | 6'b001000, 1'b1, "R3"));
    if (cfg[1]) q.push_back(mk(6'b001100, 1'b1, "R4"));
    sp = wr ? 6'b001010 : 6'b000100;
    for (int i = 0; i < nstrb; i++)
      q.push_back(mk(sp, ren ? ((i < w + extra) ? 1'b0 : 1'b1) : 1'b0,
                     ren ? "R6" : "R5"));
    for (int i = 0; i < 1 + int'(cfg[0]); i++)
      q.push_back(mk({4'b0011, wr, 1'b0}, 1'b1, wr ? "R9" : "R7"));
    q.push_back(mk(6'b011101, 1'b1, "R8"));
    rem = (wr && cfg[4]) ? 1 : 0;
    if (rem == 1) q.push_back(mk(IDLE_PINS, 1'b1, "R10"));
    turn_m    = !wr && cfg[6];
    req       = 1'b1;
    req_write = wr;
    wait_cfg  = cfg;
    rdy_en    = ren;
    repeat (n_pre) tick();
    tick();
    req       = 1'b0;
    wait_cfg  = ~cfg;   // R13: late changes must not matter
    req_write = !wr;
    if (poke) begin
      tick();
      req = 1'b1;       // R12: request while busy
      tick();
      req = 1'b0;
    end
    while (q.size() > rem) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick();
    tick();
    rst = 1'b0;
    tick();
    idle_tag = "R12";
    // R2 R5: plain read, zero waits
    access(1'b0, 16'h0000, 1'b0, 0, 1'b0, 1'b0);  flush();
    // R5 R9 R12 R13: write, three waits, busy request
    access(1'b1, 16'h3000, 1'b0, 0, 1'b0, 1'b1);  flush();
    // R3: chip select delayed behind address strobe
    access(1'b0, 16'h0004, 1'b0, 0, 1'b0, 1'b0);  flush();
    // R4 R7: setup and hold extensions on a write
    access(1'b1, 16'h2003, 1'b0, 0, 1'b0, 1'b0);  flush();
    // R6: ready stretches by three cycles
    access(1'b0, 16'h2000, 1'b1, 3, 1'b0, 1'b0);  flush();
    // R6: ready low but disabled
    access(1'b0, 16'h1000, 1'b0, 0, 1'b0, 1'b0);  flush();
    // R10: write recovery then back-to-back read
    access(1'b1, 16'h0010, 1'b0, 0, 1'b0, 1'b0);
    access(1'b0, 16'h0000, 1'b0, 0, 1'b1, 1'b0);  flush();
    // R10: write without recovery then back-to-back write
    access(1'b1, 16'h0000, 1'b0, 0, 1'b0, 1'b0);
    access(1'b1, 16'h1000, 1'b0, 0, 1'b1, 1'b0);  flush();
    // R11: flagged read, back-to-back write gets turnaround
    access(1'b0, 16'h0040, 1'b0, 0, 1'b0, 1'b0);
    access(1'b1, 16'h0000, 1'b0, 0, 1'b1, 1'b0);  flush();
    // R11: flagged read, back-to-back read gets none
    access(1'b0, 16'h0040, 1'b0, 0, 1'b0, 1'b0);
    access(1'b0, 16'h0000, 1'b0, 0, 1'b1, 1'b0);  flush();
    // R11: flagged read, idle gap, write still gets turnaround
    access(1'b0, 16'h1040, 1'b0, 0, 1'b0, 1'b0);  flush();
    access(1'b1, 16'h0000, 1'b0, 0, 1'b0, 1'b0);  flush();
    // R11: unflagged read then write, no gap
    access(1'b0, 16'h0000, 1'b0, 0, 1'b0, 1'b0);
    access(1'b1, 16'h0000, 1'b0, 0, 1'b1, 1'b0);  flush();
    // all options with ready stretch on a write, R6 R7 R10
    access(1'b1, 16'h7057, 1'b1, 2, 1'b0, 1'b1);
    access(1'b0, 16'h0002, 1'b0, 0, 1'b1, 1'b0);  flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule